// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor front end and a cache controller. Each request it accepts carries an address, a request type, a byte length, an access mode and, for write-class requests, the bytes to write. The block turns the request into a controller command and keeps it in a tracking table until the controller reports the line as complete. It then returns the request identifier, the data and the measured latency to the requester.

Requests are split by class into two small fully associative tables, both keyed by cache-line address. Loads and instruction fetches go to the read table. Stores, read-modify-write halves and locked accesses go to the write table. A line can be tracked in only one table at a time, and the total number of tracked requests is capped. A request that would break either rule, that crosses a line boundary, or that carries an unknown type is refused in the cycle it is presented. A refused request gets no identifier.

While anything is in flight, a periodic age scan looks for an entry that has waited too long. If it finds one, it raises a sticky hang flag.

Top module: `mreq_tracker`

## Requirements
- R1: Types 2 (store), 3 (atomic read half), 4 (atomic write half), 5 (locked read) and 6 (locked write) are held in the write table. Types 0 (load) and 1 (fetch) are held in the read table. A completion only retires an entry if its `cmp_wr` flag selects the table that holds the line. Otherwise `done_valid` stays low and nothing changes.
- R2: A request is refused while `busy_cnt` is at or above MAX_OUT.
- R3: A request is refused if its line (address bits above the offset) is already tracked in either table.
- R4: A request is refused if offset plus length exceeds the line size in bytes, or if its type code is 7.
- R5: `busy_cnt` rises by one per accepted request and falls by one per retired entry. It always equals the sum of the two table occupancies.
- R6: `iss_kind` maps the request type to a controller command: fetch→0, load→1, store, locked read and locked write→2, both atomic halves→3. `iss_line` carries the line address, and `iss_valid` equals `req_ok`.
- R7: `iss_priv` is 1 for mode 1 (supervisor). It is 0 for every other mode (user, device, spare).
- R8: Accepted requests receive identifiers 0, 1, 2, … in acceptance order, shown on `req_id` during the accepting cycle. Refusals do not consume an identifier. A completion returns the stored identifier on `done_id`.
- R9: On completion of a read-table entry, `done_data` byte b equals `cmp_data` byte (offset+b) for b < length, and zero above.
- R10: On completion of a write-table entry, `done_data` is `cmp_data` with bytes offset … offset+length−1 replaced by bytes 0 … length−1 of the stored write data.
- R11: `done_lat` equals the completion cycle minus the acceptance cycle. `done_lat_valid` is high with a completion only when that value is non-zero.
- R12: While `busy_cnt` is non-zero, an age scan runs every THRESH cycles. Its phase restarts when the tables empty, so the first scan falls in the THRESH-th cycle after an accept into empty tables. If any entry's age is at least THRESH at a scan, `hang_err` rises in the next cycle and stays high until reset. No scan runs while empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request presented |
| req_type | input | 3 | Request type code |
| req_addr | input | ADDR_W | Byte address |
| req_len | input | LEN_W | Byte count, 0 to LINE_B |
| req_mode | input | 2 | Access mode: 0 user, 1 supervisor, 2 device |
| req_wdata | input | 8*LINE_B | Write bytes, byte 0 first |
| req_ok | output | 1 | Request accepted this cycle |
| req_id | output | ID_W | Identifier given to the accepted request |
| iss_valid | output | 1 | Controller command valid |
| iss_line | output | ADDR_W-log2(LINE_B) | Line address of the command |
| iss_kind | output | 2 | Controller command kind |
| iss_priv | output | 1 | Privileged access |
| cmp_valid | input | 1 | Controller completion |
| cmp_wr | input | 1 | Completion targets the write table |
| cmp_line_addr | input | ADDR_W-log2(LINE_B) | Completed line |
| cmp_data | input | 8*LINE_B | Line contents from the controller |
| done_valid | output | 1 | Completion returned to requester |
| done_id | output | ID_W | Identifier of the completed request |
| done_data | output | 8*LINE_B | Load bytes or merged line |
| done_lat | output | TS_W | Cycles from accept to completion |
| done_lat_valid | output | 1 | Latency non-zero |
| busy_cnt | output | CNT_W | Requests in flight |
| hang_err | output | 1 | Sticky possible-deadlock flag |

## Verification
Assertions check on every cycle that the in-flight count matches the table occupancies and never exceeds the cap. They also check that a line never matches two entries of one table, that identifiers step only on acceptance, and that the hang flag never drops. Only the bench scenarios can show the refusal reasons, the command and mode mapping, the byte extraction and merge, the latency values and the exact cycle of the hang flag. A random mix of requests over a small pool of lines drives conflicts, over-long spans and limit hits, and a scoreboard predicts each of those outputs.

// File: rtl/mreq_pkg.sv
package mreq_pkg;

    // Request type codes seen at the front end.
    typedef enum logic [2:0] {
        RQ_LOAD    = 3'd0,
        RQ_FETCH   = 3'd1,
        RQ_STORE   = 3'd2,
        RQ_ATOM_RD = 3'd3,
        RQ_ATOM_WR = 3'd4,
        RQ_LOCK_RD = 3'd5,
        RQ_LOCK_WR = 3'd6,
        RQ_BAD     = 3'd7
    } rq_type_e;

    // Command kinds understood by the cache controller.
    typedef enum logic [1:0] {
        CK_FETCH  = 2'd0,
        CK_LOAD   = 2'd1,
        CK_STORE  = 2'd2,
        CK_ATOMIC = 2'd3
    } ctl_kind_e;

    localparam logic [1:0] MODE_SUPER = 2'd1;

endpackage

// File: rtl/mreq_xlate.sv
// Translates a request type and mode into a controller command.
// Assumes: pure combinational; type code 7 is flagged illegal.
module mreq_xlate
    import mreq_pkg::*;
(
    input  logic [2:0] rtype,
    input  logic [1:0] rmode,
    output logic [1:0] kind,
    output logic       priv,
    output logic       wr_class,
    output logic       legal
);

    // Decode class, command kind and legality from the type code.
    always_comb begin
        legal    = 1'b1;
        wr_class = 1'b1;
        kind     = CK_STORE;
        case (rq_type_e'(rtype))
            RQ_LOAD:    begin kind = CK_LOAD;   wr_class = 1'b0; end
            RQ_FETCH:   begin kind = CK_FETCH;  wr_class = 1'b0; end
            RQ_STORE, RQ_LOCK_RD, RQ_LOCK_WR: kind = CK_STORE;
            RQ_ATOM_RD, RQ_ATOM_WR:           kind = CK_ATOMIC;
            default:    begin legal = 1'b0; wr_class = 1'b0; end
        endcase
    end

    // Only supervisor mode is privileged; user, device and spare are not.
    assign priv = (rmode == MODE_SUPER);

endmodule

// File: rtl/mreq_table.sv
// Small fully associative table of in-flight requests keyed by line tag.
// Stores an opaque payload and an issue timestamp per entry.
// Assumes: caller never allocates a tag already present, nor into a full table.
module mreq_table #(
    parameter int ENT    = 4,
    parameter int TAG_W  = 13,
    parameter int PAY_W  = 15,
    parameter int TS_W   = 16,
    parameter int THRESH = 64,
    localparam int OCC_W = $clog2(ENT + 1),
    localparam int IDX_W = (ENT > 1) ? $clog2(ENT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TS_W-1:0]  now,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             alloc_en,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic [PAY_W-1:0] alloc_pay,
    input  logic             fr_en,
    input  logic [TAG_W-1:0] fr_tag,
    output logic             fr_hit,
    output logic [PAY_W-1:0] fr_pay,
    output logic [TS_W-1:0]  fr_ts,
    input  logic             chk,
    output logic             aged,
    output logic [OCC_W-1:0] occ,
    output logic             full
);

    logic [ENT-1:0]   vld;
    logic [TAG_W-1:0] tag_q [ENT];
    logic [PAY_W-1:0] pay_q [ENT];
    logic [TS_W-1:0]  ts_q  [ENT];
    logic [ENT-1:0]   lk_vec, fr_vec, old_vec;
    logic [IDX_W-1:0] free_idx;

    // Per-entry tag compares and age tests.
    always_comb begin
        for (int i = 0; i < ENT; i++) begin
            lk_vec[i]  = vld[i] && (tag_q[i] == lk_tag);
            fr_vec[i]  = vld[i] && (tag_q[i] == fr_tag);
            old_vec[i] = vld[i] && ((now - ts_q[i]) >= TS_W'(THRESH));
        end
    end

    // Select the retiring entry's contents, the first free slot and the occupancy.
    always_comb begin
        fr_pay   = '0;
        fr_ts    = '0;
        free_idx = '0;
        occ      = '0;
        for (int i = ENT - 1; i >= 0; i--) begin
            if (fr_vec[i]) begin
                fr_pay = pay_q[i];
                fr_ts  = ts_q[i];
            end
            if (!vld[i]) free_idx = IDX_W'(i);
        end
        for (int i = 0; i < ENT; i++) occ = occ + OCC_W'(vld[i]);
    end

    assign lk_hit = |lk_vec;
    assign fr_hit = |fr_vec;
    assign full   = &vld;
    assign aged   = chk && (|old_vec);

    // Valid bits: clear on retire, set on allocate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            for (int i = 0; i < ENT; i++) begin
                if (fr_en && fr_vec[i]) vld[i] <= 1'b0;
                if (alloc_en && !full && (free_idx == IDX_W'(i))) vld[i] <= 1'b1;
            end
        end
    end

    // Entry contents: written on allocate, no reset needed.
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENT; i++) begin
            if (alloc_en && !full && (free_idx == IDX_W'(i))) begin
                tag_q[i] <= alloc_tag;
                pay_q[i] <= alloc_pay;
                ts_q[i]  <= now;
            end
        end
    end

    // R3
    uniq_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec) && $onehot0(fr_vec));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !full);

endmodule

// File: rtl/mreq_tracker.sv
// Tracks memory requests from accept to controller completion.
// Read-class and write-class requests live in separate tables; a line may
// be tracked once. Returns identifier, data and latency on completion, and
// scans entry ages periodically for a possible deadlock.
// Assumes: the controller completes each line once, naming the right table.
module mreq_tracker #(
    parameter int ADDR_W  = 16,
    parameter int LINE_B  = 8,
    parameter int RD_ENT  = 4,
    parameter int WR_ENT  = 4,
    parameter int MAX_OUT = 4,
    parameter int ID_W    = 8,
    parameter int TS_W    = 16,
    parameter int THRESH  = 64,
    localparam int OFF_W  = $clog2(LINE_B),
    localparam int LEN_W  = $clog2(LINE_B + 1),
    localparam int TAG_W  = ADDR_W - OFF_W,
    localparam int LINE_W = 8 * LINE_B,
    localparam int CNT_W  = $clog2(RD_ENT + WR_ENT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_type,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [1:0]        req_mode,
    input  logic [LINE_W-1:0] req_wdata,
    output logic              req_ok,
    output logic [ID_W-1:0]   req_id,
    output logic              iss_valid,
    output logic [TAG_W-1:0]  iss_line,
    output logic [1:0]        iss_kind,
    output logic              iss_priv,
    input  logic              cmp_valid,
    input  logic              cmp_wr,
    input  logic [TAG_W-1:0]  cmp_line_addr,
    input  logic [LINE_W-1:0] cmp_data,
    output logic              done_valid,
    output logic [ID_W-1:0]   done_id,
    output logic [LINE_W-1:0] done_data,
    output logic [TS_W-1:0]   done_lat,
    output logic              done_lat_valid,
    output logic [CNT_W-1:0]  busy_cnt,
    output logic              hang_err
);

    localparam int RP_W   = OFF_W + LEN_W + ID_W;
    localparam int WP_W   = LINE_W + RP_W;
    localparam int TICK_W = $clog2(THRESH + 1);
    localparam int RO_W   = $clog2(RD_ENT + 1);
    localparam int WO_W   = $clog2(WR_ENT + 1);

    logic [TS_W-1:0]   now;
    logic [ID_W-1:0]   next_id;
    logic [TICK_W-1:0] tick;
    logic              wr_cls, legal, span_bad, tgt_full, scan;
    logic              rd_lk, wr_lk, rd_fr, wr_fr, rd_full, wr_full, rd_aged, wr_aged;
    logic [RP_W-1:0]   rd_pay, meta;
    logic [WP_W-1:0]   wr_pay;
    logic [TS_W-1:0]   rd_ts, wr_ts;
    logic [RO_W-1:0]   rd_occ;
    logic [WO_W-1:0]   wr_occ;
    logic [OFF_W-1:0]  r_off, e_off;
    logic [LEN_W-1:0]  e_len;
    logic [LINE_W-1:0] e_wd, ld_bytes, st_line;

    assign iss_line = req_addr[ADDR_W-1:OFF_W];
    assign r_off    = req_addr[OFF_W-1:0];

    mreq_xlate u_xlate (
        .rtype(req_type), .rmode(req_mode), .kind(iss_kind),
        .priv(iss_priv), .wr_class(wr_cls), .legal(legal)
    );

    // Acceptance: legal type, fits in one line, under the cap, line not tracked.
    always_comb begin
        span_bad = (int'(r_off) + int'(req_len)) > LINE_B;
        tgt_full = wr_cls ? wr_full : rd_full;
        req_ok   = req_valid && legal && !span_bad && (int'(busy_cnt) < MAX_OUT)
                   && !rd_lk && !wr_lk && !tgt_full;
    end
    assign iss_valid = req_ok;
    assign req_id    = next_id;

    mreq_table #(.ENT(RD_ENT), .TAG_W(TAG_W), .PAY_W(RP_W), .TS_W(TS_W), .THRESH(THRESH)) u_rd (
        .clk(clk), .rst_n(rst_n), .now(now),
        .lk_tag(iss_line), .lk_hit(rd_lk),
        .alloc_en(req_ok && !wr_cls), .alloc_tag(iss_line), .alloc_pay({r_off, req_len, next_id}),
        .fr_en(cmp_valid && !cmp_wr), .fr_tag(cmp_line_addr), .fr_hit(rd_fr),
        .fr_pay(rd_pay), .fr_ts(rd_ts),
        .chk(scan), .aged(rd_aged), .occ(rd_occ), .full(rd_full)
    );

    mreq_table #(.ENT(WR_ENT), .TAG_W(TAG_W), .PAY_W(WP_W), .TS_W(TS_W), .THRESH(THRESH)) u_wr (
        .clk(clk), .rst_n(rst_n), .now(now),
        .lk_tag(iss_line), .lk_hit(wr_lk),
        .alloc_en(req_ok && wr_cls), .alloc_tag(iss_line),
        .alloc_pay({req_wdata, r_off, req_len, next_id}),
        .fr_en(cmp_valid && cmp_wr), .fr_tag(cmp_line_addr), .fr_hit(wr_fr),
        .fr_pay(wr_pay), .fr_ts(wr_ts),
        .chk(scan), .aged(wr_aged), .occ(wr_occ), .full(wr_full)
    );

    // Unpack the retiring entry from whichever table the completion names.
    always_comb begin
        meta       = cmp_wr ? wr_pay[RP_W-1:0] : rd_pay;
        done_id    = meta[ID_W-1:0];
        e_len      = meta[ID_W +: LEN_W];
        e_off      = meta[ID_W + LEN_W +: OFF_W];
        e_wd       = wr_pay[RP_W +: LINE_W];
        done_valid = cmp_valid && (cmp_wr ? wr_fr : rd_fr);
        done_lat   = now - (cmp_wr ? wr_ts : rd_ts);
        done_lat_valid = done_valid && (done_lat != '0);
    end

    // Byte extraction for loads and byte merge for writes.
    always_comb begin
        ld_bytes = '0;
        st_line  = cmp_data;
        for (int b = 0; b < LINE_B; b++) begin
            if ((b < int'(e_len)) && ((int'(e_off) + b) < LINE_B))
                ld_bytes[b*8 +: 8] = cmp_data[(int'(e_off) + b)*8 +: 8];
            if ((b >= int'(e_off)) && (b < int'(e_off) + int'(e_len)))
                st_line[b*8 +: 8] = e_wd[(b - int'(e_off))*8 +: 8];
        end
        done_data = cmp_wr ? st_line : ld_bytes;
    end

    assign scan = (busy_cnt != '0) && (tick == TICK_W'(THRESH - 1));

    // Timestamp, identifier, in-flight count, scan phase and hang flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now      <= '0;
            next_id  <= '0;
            busy_cnt <= '0;
            tick     <= '0;
            hang_err <= 1'b0;
        end else begin
            now      <= now + 1'b1;
            if (req_ok) next_id <= next_id + 1'b1;
            busy_cnt <= busy_cnt + CNT_W'(req_ok) - CNT_W'(done_valid);
            if (busy_cnt == '0 || scan) tick <= '0;
            else                        tick <= tick + 1'b1;
            if (rd_aged || wr_aged) hang_err <= 1'b1;
        end
    end

    // R5
    cnt_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(busy_cnt) == int'(rd_occ) + int'(wr_occ));

    // R2
    cap_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(busy_cnt) <= MAX_OUT);

    // R8
    id_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ok |=> (next_id - $past(next_id)) == ID_W'(1));

    // R8
    id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ok |=> $stable(next_id));

    // R12
    hang_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hang_err |=> hang_err);

endmodule

// File: tb/mreq_tracker_test.sv
module mreq_tracker_test;

    localparam int CLK_P  = 10;
    localparam int THRESH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_type = '0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_len = '0;
    logic [1:0]  req_mode = '0;
    logic [63:0] req_wdata = '0;
    logic        req_ok, iss_valid, iss_priv;
    logic [7:0]  req_id, done_id;
    logic [12:0] iss_line;
    logic [1:0]  iss_kind;
    logic        cmp_valid = 1'b0, cmp_wr = 1'b0;
    logic [12:0] cmp_line_addr = '0;
    logic [63:0] cmp_data = '0;
    logic        done_valid, done_lat_valid, hang_err;
    logic [63:0] done_data;
    logic [15:0] done_lat;
    logic [3:0]  busy_cnt;

    mreq_tracker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
        .req_addr(req_addr), .req_len(req_len), .req_mode(req_mode), .req_wdata(req_wdata),
        .req_ok(req_ok), .req_id(req_id), .iss_valid(iss_valid), .iss_line(iss_line),
        .iss_kind(iss_kind), .iss_priv(iss_priv), .cmp_valid(cmp_valid), .cmp_wr(cmp_wr),
        .cmp_line_addr(cmp_line_addr), .cmp_data(cmp_data), .done_valid(done_valid),
        .done_id(done_id), .done_data(done_data), .done_lat(done_lat),
        .done_lat_valid(done_lat_valid), .busy_cnt(busy_cnt), .hang_err(hang_err)
    );

    always #(CLK_P/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0;

    // Scoreboard of in-flight requests
    bit          m_v   [8];
    logic [12:0] m_line[8];
    logic [2:0]  m_off [8];
    logic [3:0]  m_len [8];
    bit          m_wr  [8];
    logic [7:0]  m_id  [8];
    logic [63:0] m_wd  [8];
    int          m_cyc [8];
    int          m_cnt = 0;
    logic [7:0]  nid = '0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic bit is_wr(input logic [2:0] t);
        return (t >= 3'd2) && (t <= 3'd6);
    endfunction

    function automatic logic [1:0] kind_of(input logic [2:0] t);
        case (t)
            3'd0: return 2'd1;
            3'd1: return 2'd0;
            3'd3, 3'd4: return 2'd3;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [63:0] ld_exp(input logic [63:0] line, input logic [2:0] off, input logic [3:0] len);
        logic [63:0] r = '0;
        for (int b = 0; b < 8; b++)
            if (b < int'(len)) r[b*8 +: 8] = line[(int'(off)+b)*8 +: 8];
        return r;
    endfunction

    function automatic logic [63:0] st_exp(input logic [63:0] line, input logic [2:0] off,
                                           input logic [3:0] len, input logic [63:0] wd);
        logic [63:0] r = line;
        for (int b = 0; b < 8; b++)
            if (b >= int'(off) && b < int'(off) + int'(len)) r[b*8 +: 8] = wd[(b-int'(off))*8 +: 8];
        return r;
    endfunction

    function automatic bit line_busy(input logic [12:0] ln);
        for (int i = 0; i < 8; i++) if (m_v[i] && m_line[i] == ln) return 1'b1;
        return 1'b0;
    endfunction

    task automatic send(input logic [2:0] t, input logic [15:0] a, input logic [3:0] l,
                        input logic [1:0] m, input logic [63:0] wd);
        bit exp_ok;
        string why;
        @(negedge clk);
        req_valid = 1'b1; req_type = t; req_addr = a; req_len = l; req_mode = m; req_wdata = wd;
        #1;
        exp_ok = 1'b1; why = "R8";
        if (t == 3'd7 || int'(a[2:0]) + int'(l) > 8) begin exp_ok = 0; why = "R4"; end
        else if (line_busy(a[15:3]))                 begin exp_ok = 0; why = "R3"; end
        else if (m_cnt >= 4)                         begin exp_ok = 0; why = "R2"; end
        check(req_ok == exp_ok, why, 64'(req_ok), 64'(exp_ok));
        if (exp_ok) begin
            check(req_id == nid, "R8", 64'(req_id), 64'(nid));
            check(iss_valid && iss_kind == kind_of(t) && iss_line == a[15:3], "R6",
                  64'({iss_valid, iss_line, iss_kind}), 64'({1'b1, a[15:3], kind_of(t)}));
            check(iss_priv == (m == 2'd1), "R7", 64'(iss_priv), 64'(m == 2'd1));
        end
        @(posedge clk);
        if (exp_ok) begin
            for (int i = 0; i < 8; i++) begin
                if (!m_v[i]) begin
                    m_v[i] = 1; m_line[i] = a[15:3]; m_off[i] = a[2:0]; m_len[i] = l;
                    m_wr[i] = is_wr(t); m_id[i] = nid; m_wd[i] = wd; m_cyc[i] = cyc;
                    break;
                end
            end
            m_cnt++; nid++;
        end
        #1 req_valid = 1'b0;
        check(int'(busy_cnt) == m_cnt, "R5", 64'(busy_cnt), 64'(m_cnt));
    endtask

    task automatic complete(input int s, input bit wrong, input logic [63:0] ld);
        logic [63:0] exp_d;
        int lat;
        @(negedge clk);
        cmp_valid = 1'b1; cmp_wr = m_wr[s] ^ wrong; cmp_line_addr = m_line[s]; cmp_data = ld;
        #1;
        if (wrong) begin
            check(done_valid == 1'b0, "R1", 64'(done_valid), 64'd0);
        end else begin
            lat = cyc - m_cyc[s];
            exp_d = m_wr[s] ? st_exp(ld, m_off[s], m_len[s], m_wd[s]) : ld_exp(ld, m_off[s], m_len[s]);
            check(done_valid == 1'b1, "R1", 64'(done_valid), 64'd1);
            check(done_id == m_id[s], "R8", 64'(done_id), 64'(m_id[s]));
            check(done_data == exp_d, m_wr[s] ? "R10" : "R9", done_data, exp_d);
            check(int'(done_lat) == lat && done_lat_valid == (lat != 0), "R11",
                  64'({done_lat_valid, done_lat}), 64'({lat != 0, 16'(lat)}));
        end
        @(posedge clk);
        if (!wrong) begin m_v[s] = 0; m_cnt--; end
        #1 cmp_valid = 1'b0;
        check(int'(busy_cnt) == m_cnt, "R5", 64'(busy_cnt), 64'(m_cnt));
    endtask

    task automatic drain();
        for (int k = 0; k < 8; k++) begin
            int s = -1;
            int start = int'($urandom % 8);
            for (int j = 0; j < 8; j++)
                if (s < 0 && m_v[(start + j) % 8]) s = (start + j) % 8;
            if (s >= 0) complete(s, 1'b0, {$urandom, $urandom});
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 8; i++) m_v[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(busy_cnt == 0 && !hang_err && !done_valid && !req_ok, "R5",
              64'({busy_cnt, hang_err, done_valid, req_ok}), 64'd0);

        // Directed corners
        send(3'd0, 16'h0103, 4'd4, 2'd0, 64'h0);                 // load accepted, id 0
        send(3'd2, 16'h0100, 4'd2, 2'd1, 64'h1111);              // same line: R3
        send(3'd1, 16'h0206, 4'd4, 2'd2, 64'h0);                 // crosses line: R4
        send(3'd7, 16'h0300, 4'd1, 2'd0, 64'h0);                 // reserved type: R4
        send(3'd1, 16'h0204, 4'd4, 2'd2, 64'h0);                 // fetch, device mode
        send(3'd5, 16'h030A, 4'd3, 2'd1, 64'h00CC_BBAA);         // locked read, supervisor
        send(3'd3, 16'h0410, 4'd8, 2'd3, 64'h0102_0304_0506_0708);
        send(3'd0, 16'h0500, 4'd1, 2'd0, 64'h0);                 // cap reached: R2
        complete(0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);              // wrong table: R1
        complete(0, 1'b0, 64'h8877_6655_4433_2211);
        complete(2, 1'b0, 64'hF0E0_D0C0_B0A0_9080);
        complete(1, 1'b0, 64'h0F0E_0D0C_0B0A_0908);
        complete(3, 1'b0, 64'h0);

        // Random bursts over a small pool of lines
        for (int it = 0; it < 300; it++) begin
            int n = 1 + int'($urandom % 6);
            for (int k = 0; k < n; k++) begin
                logic [12:0] ln = 13'h20 + 13'($urandom % 6);
                send(3'($urandom % 8), {ln, 3'($urandom % 8)}, 4'($urandom % 9),
                     2'($urandom % 4), {$urandom, $urandom});
            end
            drain();
        end
        check(hang_err == 1'b0, "R12", 64'(hang_err), 64'd0);

        // Deadlock scan: a single entry left waiting
        begin
            int c0;
            send(3'd0, 16'h0700, 4'd2, 2'd0, 64'h0);
            c0 = cyc - 1;
            while (cyc < c0 + THRESH) @(negedge clk);
            #1 check(hang_err == 1'b0, "R12", 64'(hang_err), 64'd0);
            @(negedge clk);
            #1 check(hang_err == 1'b1, "R12", 64'(hang_err), 64'd1);
            drain();
            check(hang_err == 1'b1, "R12", 64'(hang_err), 64'd1);
        end

        summary();
        $finish;
    end

endmodule